// File: doc/BRIEF.md
# Per-Queue Fetch Credit Tracker

This block sits on the user side of a descriptor engine. It consumes the stream of per-queue status events from that engine and hands fetch credits back to it. For each queue it keeps three counters: the work announced by events and not yet turned into credits, the credits handed out, and the descriptors that have come back. It also keeps a flag for a pending interrupt credit, used in bypass mode.

The status input never back-pressures. An ordinary event adds its count to the queue's pending work. An arbiter then turns that work into credits, at most one per cycle, taking queues in round-robin order.

An invalidate event carries a different count: the number of credits the engine still holds for that queue. The tracker subtracts that figure from its own outstanding total (credits granted minus descriptors received). The result is the number of descriptors still in flight. The queue then drains until that many descriptors have arrived. A descriptor for a queue that is neither open nor draining raises a sticky error.

Each queue runs a small state machine with three states:
- `ST_IDLE`: the queue is closed.
- `ST_ACTIVE`: the queue is open and may receive credits.
- `ST_DRAIN`: the queue is waiting for in-flight descriptors after an invalidate.

The transitions between them are:
- `T_OPEN` (idle to active): taken on a normal event.
- `T_INVAL` (active to drain): taken on an invalidate event that leaves descriptors still in flight.
- `T_QUIT` (active to idle): taken on an invalidate event that leaves nothing in flight.
- `T_SETTLE` (drain to idle): taken when the last expected descriptor arrives.

An invalidate event that reaches an idle queue, and any event that reaches a draining queue, leaves the state unchanged.

Top module: `fct_credit_tracker`

## Requirements
- R1: `evt_ready` is 1 in every cycle after reset.
- R2: An event with `evt_inv`=0 for an idle or active queue makes that queue active and adds `evt_count` to its pending work. The total number of credits issued to a queue equals the sum of the counts it received while active.
- R3: At most one credit is issued per cycle. Eligible queues are active queues with nonzero pending work. They are served round-robin, starting after the queue last served. Example: queue 1 gets count 3 in one cycle and queue 2 gets count 3 in the next. The credits then come out in the order 1,2,1,2,1,2.
- R4: An event sampled at clock edge k for a queue with no other work produces `crd_valid`=1 for that queue after edge k+1, and not after edge k.
- R5: An invalidate event (`evt_inv`=1) for an active queue clears its pending work. It sets the expected-arrival count to (credits granted − descriptors received − `evt_count`), floored at 0. If that count is nonzero the queue enters drain (`q_draining` bit set). Otherwise it returns to idle.
- R6: A draining queue receives no credits, and events sent to it have no effect.
- R7: Each descriptor (`dsc_valid`) for a draining queue lowers its expected count by one. When the count reaches zero the queue goes idle, and its `q_draining` and `q_active` bits are both 0.
- R8: A descriptor for an idle queue sets `err_flag`. Only reset clears it.
- R9: An event with `evt_irq_arm`=1 sets bit `evt_qid` of `irq_pend` after the edge that samples it. `irq_ack` bit q clears bit q. If a set and a clear reach the same bit in the same cycle, the set wins.
- R10: After reset `crd_valid`, `q_active`, `q_draining`, `irq_pend` and `err_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Status event present |
| evt_ready | output | 1 | Always 1; the tracker accepts every event |
| evt_qid | input | QID_W | Queue the event refers to |
| evt_count | input | CNT_W | New work, or credits held by the engine on invalidate |
| evt_irq_arm | input | 1 | Event carries an interrupt credit |
| evt_inv | input | 1 | Queue invalidated |
| dsc_valid | input | 1 | A descriptor arrived |
| dsc_qid | input | QID_W | Queue of the arriving descriptor |
| irq_ack | input | NUM_Q | Per-queue clear of the pending interrupt credit |
| crd_valid | output | 1 | A fetch credit is issued this cycle |
| crd_qid | output | QID_W | Queue receiving the credit |
| q_active | output | NUM_Q | Per-queue active state |
| q_draining | output | NUM_Q | Per-queue drain state |
| irq_pend | output | NUM_Q | Pending interrupt credits |
| err_flag | output | 1 | Sticky error for a descriptor with no open queue |

## Verification
The scoreboard predicts the exact credit sequence when two queues compete. A pointer that fails to advance would give one queue a run of consecutive credits instead of alternating. An invalidate is sent after a descriptor has already returned, and the floor-at-zero case is exercised too. A design that ignored the descriptors already received, or wrapped the subtraction below zero, would stay in drain forever. A design that left pending work in place would keep issuing credits after the invalidate. Events sent to a draining queue, and descriptors sent to an idle one, check that the first cause no credits and the second sets the sticky error.

// File: rtl/fct_pkg.sv
package fct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DRAIN  = 2'd2
    } qstate_e;
endpackage

// File: rtl/fct_rr_arb.sv
module fct_rr_arb #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);
    logic [IDX_W-1:0] last_q;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int cand;
            cand = (int'(last_q) + off) % N;
            if (!gnt_any && req[cand]) begin
                gnt_any   = 1'b1;
                gnt_idx   = IDX_W'(cand);
                gnt[cand] = 1'b1;
            end
        end
    end

    // Pointer starts at the top index so queue 0 is searched first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDX_W'(N - 1);
        end else if (gnt_any) begin
            last_q <= gnt_idx;
        end
    end
endmodule

// File: rtl/fct_queue_slot.sv
module fct_queue_slot
    import fct_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int CTR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_hit,
    input  logic             evt_inv,
    input  logic             evt_irq,
    input  logic [CNT_W-1:0] evt_count,
    input  logic             dsc_hit,
    input  logic             grant,
    input  logic             irq_ack,
    output logic             eligible,
    output logic             is_active,
    output logic             is_drain,
    output logic             irq_pend,
    output logic             bad_dsc
);
    localparam logic [CTR_W-1:0] CTR_MAX = '1;

    qstate_e          state_q, state_n;
    logic [CTR_W-1:0] avail_q, avail_n;
    logic [CTR_W-1:0] gcnt_q, gcnt_n;
    logic [CTR_W-1:0] rcnt_q, rcnt_n;
    logic [CTR_W-1:0] left_q, left_n;
    logic             irq_q, irq_n;

    logic [CTR_W:0]   sum_w;
    logic [CTR_W-1:0] add_sat;
    logic [CTR_W-1:0] cnt_ext;
    logic [CTR_W-1:0] outstanding;
    logic [CTR_W-1:0] in_flight;

    assign cnt_ext     = CTR_W'(evt_count);
    assign sum_w       = {1'b0, avail_q} + {1'b0, (evt_hit && !evt_inv) ? cnt_ext : '0};
    assign add_sat     = sum_w[CTR_W] ? CTR_MAX : sum_w[CTR_W-1:0];
    assign outstanding = gcnt_q - rcnt_q - CTR_W'(dsc_hit);
    assign in_flight   = (outstanding > cnt_ext) ? (outstanding - cnt_ext) : '0;

    // Next-state and counter process.
    always_comb begin
        state_n = state_q;
        avail_n = avail_q;
        gcnt_n  = gcnt_q;
        rcnt_n  = rcnt_q;
        left_n  = left_q;
        bad_dsc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                bad_dsc = dsc_hit;
                if (evt_hit && !evt_inv) begin          // T_OPEN
                    state_n = ST_ACTIVE;
                    avail_n = add_sat;
                end
            end
            ST_ACTIVE: begin
                if (evt_hit && evt_inv) begin
                    avail_n = '0;
                    if (in_flight != '0) begin          // T_INVAL
                        state_n = ST_DRAIN;
                        left_n  = in_flight;
                    end else begin                      // T_QUIT
                        state_n = ST_IDLE;
                        gcnt_n  = '0;
                        rcnt_n  = '0;
                    end
                end else begin
                    avail_n = add_sat - CTR_W'(grant);
                    gcnt_n  = gcnt_q + CTR_W'(grant);
                    rcnt_n  = rcnt_q + CTR_W'(dsc_hit);
                end
            end
            ST_DRAIN: begin
                if (dsc_hit) begin
                    left_n = left_q - 1'b1;
                    if (left_q == CTR_W'(1)) begin       // T_SETTLE
                        state_n = ST_IDLE;
                        gcnt_n  = '0;
                        rcnt_n  = '0;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
        irq_n = (irq_q & ~irq_ack) | (evt_hit & evt_irq);
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            avail_q <= '0;
            gcnt_q  <= '0;
            rcnt_q  <= '0;
            left_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            avail_q <= avail_n;
            gcnt_q  <= gcnt_n;
            rcnt_q  <= rcnt_n;
            left_q  <= left_n;
            irq_q   <= irq_n;
        end
    end

    // Output process.
    always_comb begin
        is_active = (state_q == ST_ACTIVE);
        is_drain  = (state_q == ST_DRAIN);
        eligible  = is_active && (avail_q != '0) && !(evt_hit && evt_inv);
        irq_pend  = irq_q;
    end
endmodule

// File: rtl/fct_credit_tracker.sv
module fct_credit_tracker #(
    parameter int NUM_Q = 4,
    parameter int CNT_W = 8,
    parameter int CTR_W = 12,
    parameter int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    output logic             evt_ready,
    input  logic [QID_W-1:0] evt_qid,
    input  logic [CNT_W-1:0] evt_count,
    input  logic             evt_irq_arm,
    input  logic             evt_inv,
    input  logic             dsc_valid,
    input  logic [QID_W-1:0] dsc_qid,
    input  logic [NUM_Q-1:0] irq_ack,
    output logic             crd_valid,
    output logic [QID_W-1:0] crd_qid,
    output logic [NUM_Q-1:0] q_active,
    output logic [NUM_Q-1:0] q_draining,
    output logic [NUM_Q-1:0] irq_pend,
    output logic             err_flag
);
    logic [NUM_Q-1:0] elig;
    logic [NUM_Q-1:0] gnt;
    logic [NUM_Q-1:0] bad;
    logic [QID_W-1:0] gnt_idx;
    logic             gnt_any;
    logic             crd_valid_q;
    logic [QID_W-1:0] crd_qid_q;
    logic             err_q;

    assign evt_ready = 1'b1;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_slot
        fct_queue_slot #(
            .CNT_W (CNT_W),
            .CTR_W (CTR_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_hit   (evt_valid && (evt_qid == QID_W'(q))),
            .evt_inv   (evt_inv),
            .evt_irq   (evt_irq_arm),
            .evt_count (evt_count),
            .dsc_hit   (dsc_valid && (dsc_qid == QID_W'(q))),
            .grant     (gnt[q]),
            .irq_ack   (irq_ack[q]),
            .eligible  (elig[q]),
            .is_active (q_active[q]),
            .is_drain  (q_draining[q]),
            .irq_pend  (irq_pend[q]),
            .bad_dsc   (bad[q])
        );
    end

    fct_rr_arb #(
        .N     (NUM_Q),
        .IDX_W (QID_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (elig),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crd_valid_q <= 1'b0;
            crd_qid_q   <= '0;
            err_q       <= 1'b0;
        end else begin
            crd_valid_q <= gnt_any;
            crd_qid_q   <= gnt_any ? gnt_idx : crd_qid_q;
            err_q       <= err_q | (|bad);
        end
    end

    assign crd_valid = crd_valid_q;
    assign crd_qid   = crd_qid_q;
    assign err_flag  = err_q;
endmodule

// File: rtl/fct_checker.sv
module fct_checker #(
    parameter int NUM_Q = 4,
    parameter int QID_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid,
    input logic             evt_ready,
    input logic [QID_W-1:0] evt_qid,
    input logic             evt_irq_arm,
    input logic             crd_valid,
    input logic [QID_W-1:0] crd_qid,
    input logic [NUM_Q-1:0] q_active,
    input logic [NUM_Q-1:0] q_draining,
    input logic [NUM_Q-1:0] irq_pend,
    input logic             err_flag
);
    logic [NUM_Q-1:0] crd_onehot;
    assign crd_onehot = NUM_Q'(1) << crd_qid;

    AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ready);                                                            // R1
    AST_CRD_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        crd_valid |-> (($past(q_active) & crd_onehot) != '0));                 // R3
    AST_NO_DRAIN_CRD: assert property (@(posedge clk) disable iff (!rst_n)
        crd_valid |-> (($past(q_draining) & crd_onehot) == '0));               // R6
    AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (q_active & q_draining) == '0);                                        // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);                                                // R8
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_irq_arm) |=> irq_pend[$past(evt_qid)]);              // R9
endmodule

bind fct_credit_tracker fct_checker #(
    .NUM_Q (NUM_Q),
    .QID_W (QID_W)
) u_fct_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_ready   (evt_ready),
    .evt_qid     (evt_qid),
    .evt_irq_arm (evt_irq_arm),
    .crd_valid   (crd_valid),
    .crd_qid     (crd_qid),
    .q_active    (q_active),
    .q_draining  (q_draining),
    .irq_pend    (irq_pend),
    .err_flag    (err_flag)
);

// File: tb/tb_fct_credit_tracker.sv
module tb_fct_credit_tracker;
    localparam int NUM_Q = 4;
    localparam int CNT_W = 8;
    localparam int QID_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evt_valid = 1'b0;
    logic             evt_ready;
    logic [QID_W-1:0] evt_qid = '0;
    logic [CNT_W-1:0] evt_count = '0;
    logic             evt_irq_arm = 1'b0;
    logic             evt_inv = 1'b0;
    logic             dsc_valid = 1'b0;
    logic [QID_W-1:0] dsc_qid = '0;
    logic [NUM_Q-1:0] irq_ack = '0;
    logic             crd_valid;
    logic [QID_W-1:0] crd_qid;
    logic [NUM_Q-1:0] q_active;
    logic [NUM_Q-1:0] q_draining;
    logic [NUM_Q-1:0] irq_pend;
    logic             err_flag;

    int n_run  = 0;
    int n_fail = 0;
    logic [QID_W-1:0] exp_q[$];

    always #2 clk = ~clk;

    fct_credit_tracker #(.NUM_Q(NUM_Q), .CNT_W(CNT_W)) dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver tasks: called at a negedge, return at the next negedge.
    task automatic send_evt(input int q, input int cnt, input bit irq, input bit inv);
        evt_valid = 1'b1; evt_qid = QID_W'(q); evt_count = CNT_W'(cnt);
        evt_irq_arm = irq; evt_inv = inv;
        @(negedge clk);
        evt_valid = 1'b0; evt_irq_arm = 1'b0; evt_inv = 1'b0;
    endtask

    task automatic send_dsc(input int q);
        dsc_valid = 1'b1; dsc_qid = QID_W'(q);
        @(negedge clk);
        dsc_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every credit must match the head of the expected queue (R2, R3, R6).
    always @(negedge clk) begin
        if (rst_n && crd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected credit", int'(crd_qid), -1);
            end else begin
                logic [QID_W-1:0] e;
                e = exp_q.pop_front();
                check(crd_qid == e, "R3 credit order", int'(crd_qid), int'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state, R1 ready
        check(crd_valid == 1'b0, "R10 crd_valid", int'(crd_valid), 0);
        check(q_active == '0 && q_draining == '0, "R10 queue state", int'({q_active, q_draining}), 0);
        check(irq_pend == '0 && err_flag == 1'b0, "R10 irq/err", int'({irq_pend, err_flag}), 0);
        check(evt_ready == 1'b1, "R1 ready", int'(evt_ready), 1);

        // R4 latency and R9 irq credit on queue 3
        exp_q.push_back(2'd3);
        send_evt(3, 1, 1'b1, 1'b0);
        check(crd_valid == 1'b0, "R4 no credit after edge k", int'(crd_valid), 0);
        check(irq_pend[3] == 1'b1, "R9 irq set", int'(irq_pend[3]), 1);
        check(q_active[3] == 1'b1, "R2 queue opened", int'(q_active[3]), 1);
        @(negedge clk);
        check(crd_valid && crd_qid == 2'd3, "R4 credit after edge k+1", int'(crd_qid), 3);
        irq_ack = 4'b1000;
        send_evt(3, 0, 1'b1, 1'b0);
        irq_ack = '0;
        check(irq_pend[3] == 1'b1, "R9 set beats ack", int'(irq_pend[3]), 1);
        irq_ack = 4'b1000;
        @(negedge clk);
        irq_ack = '0;
        check(irq_pend[3] == 1'b0, "R9 ack clears", int'(irq_pend[3]), 0);

        // R3 round robin between queues 1 and 2
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(2'd1);
            exp_q.push_back(2'd2);
        end
        send_evt(1, 3, 1'b0, 1'b0);
        send_evt(2, 3, 1'b0, 1'b0);
        idle(10);
        check(exp_q.size() == 0, "R3 all round-robin credits seen", exp_q.size(), 0);

        // R5 drain entry on queue 0
        repeat (4) exp_q.push_back(2'd0);
        send_evt(0, 4, 1'b0, 1'b0);
        idle(8);
        check(exp_q.size() == 0, "R2 four credits for queue 0", exp_q.size(), 0);
        send_dsc(0);
        send_evt(0, 1, 1'b0, 1'b1);     // 4 granted - 1 received - 1 held = 2 in flight
        check(q_draining[0] == 1'b1, "R5 enters drain", int'(q_draining[0]), 1);
        check(q_active[0] == 1'b0, "R5 leaves active", int'(q_active[0]), 0);
        // R6 event during drain is ignored
        send_evt(0, 5, 1'b0, 1'b0);
        idle(5);
        check(q_draining[0] == 1'b1, "R6 event ignored in drain", int'(q_draining[0]), 1);
        // R7 drain to idle
        send_dsc(0);
        check(q_draining[0] == 1'b1, "R7 still draining after one", int'(q_draining[0]), 1);
        send_dsc(0);
        check(q_draining[0] == 1'b0 && q_active[0] == 1'b0, "R7 idle after last", int'({q_active[0], q_draining[0]}), 0);
        check(err_flag == 1'b0, "R8 no error during drain", int'(err_flag), 0);
        idle(4);
        // R8 descriptor for idle queue
        send_dsc(0);
        check(err_flag == 1'b1, "R8 error set", int'(err_flag), 1);
        idle(3);
        check(err_flag == 1'b1, "R8 error sticky", int'(err_flag), 1);

        // R5 floor at zero: queue 2 has 5 outstanding, engine reports 7 held
        repeat (2) exp_q.push_back(2'd2);
        send_evt(2, 2, 1'b0, 1'b0);
        idle(6);
        send_evt(2, 7, 1'b0, 1'b1);
        check(q_active[2] == 1'b0 && q_draining[2] == 1'b0, "R5 straight to idle", int'({q_active[2], q_draining[2]}), 0);
        idle(10);
        check(exp_q.size() == 0, "R2 credit totals", exp_q.size(), 0);
        check(evt_ready == 1'b1, "R1 ready at end", int'(evt_ready), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule